// File: doc/BRIEF.md
# Speculative Dependency-Tracking Snoop Cache

This block is a small fully associative read cache placed beside one processor that runs speculative blocks of code. Besides holding copies of memory words, every line records how the running block relies on its word: not at all, as a plain load the block depends on, or as a guessed future value. The cache watches a shared bus of memory writes made by other processors. When such a write breaks a dependency of the running block, the cache tells the processor to abort and retry the block, or to abandon it for good.

The processor issues one request per cycle: a tracked load, an untracked load (peek), a value prediction, a gating prediction (the block proceeds only if a predicate ends up at the guessed value), or a restart that opens a new block. The memory read port returns data in the same cycle it is asked, and a load response appears one cycle after the request is accepted. Lines that carry dependency information are never replaced. When a miss finds no replaceable line, the request stalls and a full flag is raised until a restart frees lines. Opcodes 5 to 7 are accepted and do nothing.

Line states used below: EMPTY, CLEAN (plain copy), WATCHED (block depends on it), GUESS_OK and GUESS_BAD (predicted word currently equal to or different from memory), GATE (block abandons if the word ends up different).

Top module: `spec_dep_cache`

## Requirements
- R1: After reset no line is held, rsp_valid_o, abort_o, abandon_o, pend_pred_o and cap_full_o are low and req_ready_o is high; the first load of any address reads memory.
- R2: A load (opcode 0) that misses makes one memory read in its accept cycle, returns the memory word with rsp_valid_o high in the next cycle, and leaves the line WATCHED.
- R3: A load that hits a CLEAN line makes no memory read, returns the cached word, and turns the line WATCHED.
- R4: A peek (opcode 3) returns the word, reads memory only on a miss, fills a missing line as CLEAN and never makes a line WATCHED; a snooped change to such a line raises no abort and a later peek returns the new word without a memory read.
- R5: A snooped write to a WATCHED line replaces its word, and abort_o pulses high for one cycle, in the cycle after the snoop, exactly when the new word differs from the old.
- R6: A predict request (opcode 1) stores the predicted word and makes exactly one memory read; the line becomes GUESS_OK if memory equals the prediction, else GUESS_BAD. pend_pred_o is high whenever any line is GUESS_BAD.
- R7: A snooped write to a GUESS_OK or GUESS_BAD line keeps the stored prediction and sets the line to GUESS_OK if the written word equals it, else GUESS_BAD; it raises no abort or abandon.
- R8: A gate request (opcode 2) stores the word without a memory read and sets the line to GATE; a snooped write of an equal word changes nothing, a different word pulses abandon_o (not abort_o) in the next cycle.
- R9: A miss may only take an EMPTY or CLEAN line. If there is none, req_ready_o is low, cap_full_o is high and no memory read happens; hits are still accepted, and tracked lines keep their address and contents.
- R10: A restart (opcode 4) turns CLEAN, WATCHED and GUESS_OK lines into CLEAN and every other line into EMPTY, so pend_pred_o drops and only the kept lines hit; a snoop in the restart cycle raises no abort or abandon.
- R11: A request whose address equals that of a snooped write in the same cycle is not accepted in that cycle.
- R12: A load that hits a GUESS_OK, GUESS_BAD or GATE line returns the stored predicted word without a memory read and leaves the state as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Processor request present |
| req_op_i | input | 3 | 0 load, 1 predict, 2 gate, 3 peek, 4 restart |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_wdata_i | input | DATA_W | Predicted word for predict and gate |
| req_ready_o | output | 1 | Request accepted this cycle |
| rsp_valid_o | output | 1 | Load or peek response valid |
| rsp_data_o | output | DATA_W | Response word |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_data_i | input | DATA_W | Memory read word, same cycle |
| snp_valid_i | input | 1 | Write seen on the shared bus |
| snp_addr_i | input | ADDR_W | Address of the snooped write |
| snp_data_i | input | DATA_W | Word of the snooped write |
| abort_o | output | 1 | One-cycle request to retry the block |
| abandon_o | output | 1 | One-cycle request to drop the block |
| pend_pred_o | output | 1 | Some prediction disagrees with memory |
| cap_full_o | output | 1 | Miss blocked, every line tracked |

## Verification
A line held in the wrong state is invisible until a snoop or a restart touches it, so every state is built on a fresh address and then probed three ways: a snoop with an equal and with a different word (abort, abandon and pend_pred_o one cycle later), then a restart followed by a load whose memory-read count shows whether the line survived. A wrong word in a line shows on rsp_data_o at the next load of that address. A wrong replacement choice shows as a lost dependency (no abort on a later snoop) or as a stall that should not occur, both visible within a few cycles.

// File: rtl/sdc_pkg.sv
// Shared types for the speculative dependency cache.
// Assumes: state and opcode codes are fixed, the processor side relies on
// the opcode values.
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY      = 3'd0,
        ST_CLEAN      = 3'd1,
        ST_WATCH      = 3'd2,
        ST_GUESS_OK   = 3'd3,
        ST_GUESS_BAD  = 3'd4,
        ST_GATE       = 3'd5
    } line_st_e;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_PREDICT = 3'd1,
        OP_GATE    = 3'd2,
        OP_PEEK    = 3'd3,
        OP_RESTART = 3'd4
    } req_op_e;

endpackage

// File: rtl/sdc_line.sv
// One cache line: address, word and speculation state.
// Applies a snooped bus write first, then either a block restart or a
// write from the request side. Raises single-cycle abort and abandon
// events (combinational) when a snoop breaks a dependency.
// Assumes: the parent never writes a line on the same cycle as a restart
// and never writes a line whose address matches the current snoop.
module sdc_line
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  line_st_e          wr_state_i,
    output line_st_e          st_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              abort_o,
    output logic              abandon_o
);

    line_st_e          st_q, st_s, st_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] data_q, data_s, data_n;
    logic              snp_hit, snp_same, ev_abort, ev_abandon;

    // Snoop effect on this line
    always_comb begin
        snp_hit    = snp_valid_i && (st_q != ST_EMPTY) && (snp_addr_i == addr_q);
        snp_same   = (snp_data_i == data_q);
        st_s       = st_q;
        data_s     = data_q;
        ev_abort   = 1'b0;
        ev_abandon = 1'b0;
        if (snp_hit) begin
            case (st_q)
                ST_CLEAN: data_s = snp_data_i;
                ST_WATCH: begin
                    data_s   = snp_data_i;
                    ev_abort = !snp_same;
                end
                ST_GUESS_OK, ST_GUESS_BAD: st_s = snp_same ? ST_GUESS_OK : ST_GUESS_BAD;
                ST_GATE:  ev_abandon = !snp_same;
                default:  ;
            endcase
        end
    end

    // Restart mapping or request write on top of the snoop result
    always_comb begin
        st_n   = st_s;
        data_n = data_s;
        addr_n = addr_q;
        if (init_i) begin
            st_n = (st_s == ST_CLEAN || st_s == ST_WATCH || st_s == ST_GUESS_OK)
                   ? ST_CLEAN : ST_EMPTY;
        end else if (wr_en_i) begin
            st_n   = wr_state_i;
            data_n = wr_data_i;
            addr_n = wr_addr_i;
        end
    end

    // Line storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_EMPTY;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_n;
            addr_q <= addr_n;
            data_q <= data_n;
        end
    end

    assign st_o      = st_q;
    assign addr_o    = addr_q;
    assign data_o    = data_q;
    assign abort_o   = ev_abort && !init_i;
    assign abandon_o = ev_abandon && !init_i;

    AST_TRACKED_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q inside {ST_WATCH, ST_GUESS_OK, ST_GUESS_BAD, ST_GATE}) && !init_i)
        |=> $stable(addr_q)); // R9

    AST_GUESS_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_GUESS_OK, ST_GUESS_BAD}) |-> !abort_o && !abandon_o); // R7

endmodule

// File: rtl/sdc_select.sv
// Priority selection over the lines: the matching line for a request and
// the lowest-numbered replaceable line for a miss.
// Assumes: at most one line matches (the parent allocates only on a miss).
module sdc_select #(
    parameter int LINES = 4,
    localparam int IW = $clog2(LINES)
) (
    input  logic [LINES-1:0] hit_vec_i,
    input  logic [LINES-1:0] free_vec_i,
    output logic             hit_any_o,
    output logic [IW-1:0]    hit_idx_o,
    output logic             free_any_o,
    output logic [IW-1:0]    free_idx_o
);

    // Encode the matching line
    always_comb begin
        hit_any_o = 1'b0;
        hit_idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (hit_vec_i[i]) begin
                hit_any_o = 1'b1;
                hit_idx_o = IW'(i);
            end
        end
    end

    // Pick the lowest replaceable line
    always_comb begin
        free_any_o = 1'b0;
        free_idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (free_vec_i[i]) begin
                free_any_o = 1'b1;
                free_idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/spec_dep_cache.sv
// Speculative dependency-tracking snoop cache, one per processor.
// Decodes one processor request per cycle against a fully associative set
// of lines, reads memory through a same-cycle read port, and reports
// broken dependencies from snooped bus writes as abort or abandon pulses.
// Assumes: LINES >= 2; memory returns mem_rd_data_i in the cycle of
// mem_rd_en_o; snooped writes already hold in memory afterwards.
module spec_dep_cache
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic              abort_o,
    output logic              abandon_o,
    output logic              pend_pred_o,
    output logic              cap_full_o
);

    localparam int IW = $clog2(LINES);

    line_st_e          st_a   [LINES];
    logic [ADDR_W-1:0] addr_a [LINES];
    logic [DATA_W-1:0] data_a [LINES];
    logic [LINES-1:0]  hit_vec, free_vec, bad_vec, abort_vec, abandon_vec, wr_line;
    logic              hit_any, free_any;
    logic [IW-1:0]     hit_idx, free_idx, tgt_idx;

    req_op_e           op;
    logic              needs_line, need_alloc, clash, accept, init_all;
    logic              wr_go, rsp_go;
    line_st_e          wr_state, hit_st;
    logic [DATA_W-1:0] wr_data, hit_data, rsp_word;

    logic              rsp_valid_q, abort_q, abandon_q;
    logic [DATA_W-1:0] rsp_data_q;

    // Per-line storage and per-line match flags
    for (genvar g = 0; g < LINES; g++) begin : g_line
        sdc_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .init_i      (init_all),
            .snp_valid_i (snp_valid_i),
            .snp_addr_i  (snp_addr_i),
            .snp_data_i  (snp_data_i),
            .wr_en_i     (wr_line[g]),
            .wr_addr_i   (req_addr_i),
            .wr_data_i   (wr_data),
            .wr_state_i  (wr_state),
            .st_o        (st_a[g]),
            .addr_o      (addr_a[g]),
            .data_o      (data_a[g]),
            .abort_o     (abort_vec[g]),
            .abandon_o   (abandon_vec[g])
        );
        assign hit_vec[g]  = (st_a[g] != ST_EMPTY) && (addr_a[g] == req_addr_i);
        assign free_vec[g] = (st_a[g] == ST_EMPTY) || (st_a[g] == ST_CLEAN);
        assign bad_vec[g]  = (st_a[g] == ST_GUESS_BAD);
        assign wr_line[g]  = wr_go && (tgt_idx == IW'(g));
    end

    sdc_select #(.LINES(LINES)) u_select (
        .hit_vec_i  (hit_vec),
        .free_vec_i (free_vec),
        .hit_any_o  (hit_any),
        .hit_idx_o  (hit_idx),
        .free_any_o (free_any),
        .free_idx_o (free_idx)
    );

    // Request acceptance: capacity stall and same-address snoop stall
    always_comb begin
        op          = req_op_e'(req_op_i);
        needs_line  = (op == OP_LOAD) || (op == OP_PREDICT) || (op == OP_GATE) || (op == OP_PEEK);
        need_alloc  = needs_line && !hit_any;
        cap_full_o  = req_valid_i && need_alloc && !free_any;
        clash       = req_valid_i && needs_line && snp_valid_i && (snp_addr_i == req_addr_i);
        req_ready_o = !(cap_full_o || clash);
        accept      = req_valid_i && req_ready_o;
        tgt_idx     = hit_any ? hit_idx : free_idx;
        hit_st      = st_a[hit_idx];
        hit_data    = data_a[hit_idx];
    end

    // Request action: memory read, line write, response word
    always_comb begin
        mem_rd_en_o   = 1'b0;
        mem_rd_addr_o = req_addr_i;
        wr_go         = 1'b0;
        wr_state      = ST_EMPTY;
        wr_data       = req_wdata_i;
        rsp_go        = 1'b0;
        rsp_word      = hit_data;
        init_all      = 1'b0;
        if (accept) begin
            case (op)
                OP_LOAD: begin
                    rsp_go = 1'b1;
                    if (hit_any) begin
                        if (hit_st == ST_CLEAN) begin
                            wr_go    = 1'b1;
                            wr_state = ST_WATCH;
                            wr_data  = hit_data;
                        end
                    end else begin
                        mem_rd_en_o = 1'b1;
                        wr_go       = 1'b1;
                        wr_state    = ST_WATCH;
                        wr_data     = mem_rd_data_i;
                        rsp_word    = mem_rd_data_i;
                    end
                end
                OP_PEEK: begin
                    rsp_go = 1'b1;
                    if (!hit_any) begin
                        mem_rd_en_o = 1'b1;
                        wr_go       = 1'b1;
                        wr_state    = ST_CLEAN;
                        wr_data     = mem_rd_data_i;
                        rsp_word    = mem_rd_data_i;
                    end
                end
                OP_PREDICT: begin
                    mem_rd_en_o = 1'b1;
                    wr_go       = 1'b1;
                    wr_state    = (mem_rd_data_i == req_wdata_i) ? ST_GUESS_OK : ST_GUESS_BAD;
                end
                OP_GATE: begin
                    wr_go    = 1'b1;
                    wr_state = ST_GATE;
                end
                OP_RESTART: init_all = 1'b1;
                default: ;
            endcase
        end
    end

    // Response and event registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            abort_q     <= 1'b0;
            abandon_q   <= 1'b0;
        end else begin
            rsp_valid_q <= rsp_go;
            if (rsp_go) rsp_data_q <= rsp_word;
            abort_q     <= |abort_vec;
            abandon_q   <= |abandon_vec;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_data_o  = rsp_data_q;
    assign abort_o     = abort_q;
    assign abandon_o   = abandon_q;
    assign pend_pred_o = |bad_vec;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_full_o |-> !req_ready_o && !mem_rd_en_o); // R9

    AST_CLASH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && snp_valid_i && snp_addr_i == req_addr_i && req_op_i != 3'd4)
        |-> !req_ready_o); // R11

    AST_ABORT_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(snp_valid_i)); // R5

    AST_ABANDON_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        abandon_o |-> $past(snp_valid_i)); // R8

    AST_GATE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 3'd2) |-> !mem_rd_en_o); // R8

endmodule

// File: tb/spec_dep_cache_test.sv
module spec_dep_cache_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [2:0] OPC_LOAD = 3'd0, OPC_PRED = 3'd1, OPC_GATE = 3'd2,
                           OPC_PEEK = 3'd3, OPC_RESTART = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_rd_en, abort, abandon, pend_pred, cap_full;
    logic [DW-1:0] rsp_data, mem_rd_data;
    logic [AW-1:0] mem_rd_addr;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;

    logic [DW-1:0] mem [256];
    int            rd_cnt = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    logic          got_rv, got_abort, got_abandon;
    logic [DW-1:0] got_rd;
    int            got_reads;

    always #5 clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr];

    always @(posedge clk) if (rst_n && mem_rd_en) rd_cnt++;

    spec_dep_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr), .mem_rd_data_i(mem_rd_data),
        .snp_valid_i(snp_valid), .snp_addr_i(snp_addr), .snp_data_i(snp_data),
        .abort_o(abort), .abandon_o(abandon), .pend_pred_o(pend_pred), .cap_full_o(cap_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One request, accepted at the next rising edge
    task automatic req(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int r0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        r0 = rd_cnt;
        @(posedge clk); #1;
        req_valid = 1'b0;
        got_rv = rsp_valid; got_rd = rsp_data; got_reads = rd_cnt - r0;
    endtask

    // One snooped bus write; memory follows it
    task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a; snp_data = d;
        @(posedge clk); #1;
        snp_valid = 1'b0;
        mem[a] = d;
        got_abort = abort; got_abandon = abandon;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] base, stored, sd;
        int post, r0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 abort", 32'(abort), 0);
        chk("R1 abandon", 32'(abandon), 0);
        chk("R1 pend", 32'(pend_pred), 0);
        chk("R1 full", 32'(cap_full), 0);
        req(OPC_LOAD, 8'h50, '0);
        chk("R1 first load reads", 32'(got_reads), 1);

        // R2: load miss then hit on a watched line
        chk("R2 rsp_valid", 32'(got_rv), 1);
        chk("R2 data", 32'(got_rd), 32'(mem[8'h50]));
        snoop(8'h50, mem[8'h50] ^ 16'h0004);
        chk("R2 watched aborts", 32'(got_abort), 1);
        req(OPC_LOAD, 8'h50, '0);
        chk("R5 snoop data taken", 32'(got_rd), 32'(mem[8'h50]));
        chk("R5 no reread", 32'(got_reads), 0);

        // R3: load on a clean line
        req(OPC_PEEK, 8'h60, '0);
        chk("R4 peek miss reads", 32'(got_reads), 1);
        req(OPC_LOAD, 8'h60, '0);
        chk("R3 no read", 32'(got_reads), 0);
        chk("R3 data", 32'(got_rd), 32'(mem[8'h60]));
        snoop(8'h60, mem[8'h60] ^ 16'h0100);
        chk("R3 now watched", 32'(got_abort), 1);

        // R4: peek keeps line untracked
        req(OPC_PEEK, 8'h61, '0);
        snoop(8'h61, mem[8'h61] ^ 16'h0020);
        chk("R4 no abort", 32'(got_abort), 0);
        req(OPC_PEEK, 8'h61, '0);
        chk("R4 new data", 32'(got_rd), 32'(mem[8'h61]));
        chk("R4 hit no read", 32'(got_reads), 0);

        // R12 and R6: load on a bad guess
        req(OPC_RESTART, '0, '0);
        req(OPC_PRED, 8'h62, 16'hBEEF);
        chk("R6 one read", 32'(got_reads), 1);
        chk("R6 pend", 32'(pend_pred), 1);
        req(OPC_LOAD, 8'h62, '0);
        chk("R12 guess word", 32'(got_rd), 32'hBEEF);
        chk("R12 no read", 32'(got_reads), 0);
        chk("R12 state kept", 32'(pend_pred), 1);
        req(OPC_GATE, 8'h63, 16'h1234);
        chk("R8 gate no read", 32'(got_reads), 0);
        req(OPC_LOAD, 8'h63, '0);
        chk("R12 gate word", 32'(got_rd), 32'h1234);

        // Sweep every line state against an equal and a different snoop
        for (int s = 0; s < 6; s++) begin
            for (int m = 0; m < 2; m++) begin
                a = 8'(32 + s * 2 + m);
                req(OPC_RESTART, '0, '0);
                base = mem[a];
                stored = base;
                case (s)
                    1: req(OPC_PEEK, a, '0);
                    2: req(OPC_LOAD, a, '0);
                    3: req(OPC_PRED, a, base);
                    4: begin stored = base ^ 16'h0101; req(OPC_PRED, a, stored); end
                    5: begin stored = base ^ 16'h00F0; req(OPC_GATE, a, stored); end
                    default: ;
                endcase
                chk("R6 pend before snoop", 32'(pend_pred), 32'(s == 4));
                sd = (m == 1) ? stored : stored ^ 16'h8000;
                snoop(a, sd);
                chk("R5 abort", 32'(got_abort), 32'(s == 2 && m == 0));
                chk("R8 abandon", 32'(got_abandon), 32'(s == 5 && m == 0));
                post = (s == 3 || s == 4) ? ((m == 1) ? 3 : 4) : s;
                chk("R7 pend after snoop", 32'(pend_pred), 32'(post == 4));
                req(OPC_RESTART, '0, '0);
                chk("R10 pend cleared", 32'(pend_pred), 0);
                req(OPC_LOAD, a, '0);
                chk("R10 kept or dropped", 32'(got_reads), 32'(!(post >= 1 && post <= 3)));
                chk("R10 data", 32'(got_rd), 32'(mem[a]));
            end
        end

        // R9: all lines tracked, miss stalls
        req(OPC_RESTART, '0, '0);
        for (int k = 0; k < 4; k++) req(OPC_LOAD, 8'(8'h70 + k), '0);
        @(negedge clk);
        req_valid = 1'b1; req_op = OPC_LOAD; req_addr = 8'h74;
        r0 = rd_cnt;
        #1;
        chk("R9 ready low", 32'(req_ready), 0);
        chk("R9 full", 32'(cap_full), 1);
        @(posedge clk); #1;
        chk("R9 no response", 32'(rsp_valid), 0);
        chk("R9 no read", 32'(rd_cnt - r0), 0);
        @(negedge clk);
        req_addr = 8'h71;
        #1;
        chk("R9 hit accepted", 32'(req_ready), 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R9 hit response", 32'(rsp_data), 32'(mem[8'h71]));
        snoop(8'h70, mem[8'h70] ^ 16'h0001);
        chk("R9 tracked kept", 32'(got_abort), 1);
        req(OPC_RESTART, '0, '0);
        req(OPC_LOAD, 8'h74, '0);
        chk("R9 after restart", 32'(got_reads), 1);

        // R11: same-address snoop and request
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = 8'h80; snp_data = 16'h7777;
        req_valid = 1'b1; req_op = OPC_LOAD; req_addr = 8'h80;
        #1;
        chk("R11 ready low", 32'(req_ready), 0);
        @(posedge clk); #1;
        snp_valid = 1'b0; req_valid = 1'b0;
        mem[8'h80] = 16'h7777;
        chk("R11 no response", 32'(rsp_valid), 0);
        req(OPC_LOAD, 8'h80, '0);
        chk("R11 later load", 32'(got_rd), 32'h7777);

        report();
    end

endmodule